// File: doc/BRIEF.md
# Trigger cell frame serializer

This block turns one board's worth of trigger cell hit records into the fixed frame that a front-end board would put on a 16-bit serial link. Simulated hit data can then drive the downstream trigger logic exactly as real hardware traffic would. Each record is 20 bits wide: a fire flag, a 7-bit timing value and a 12-bit energy value. On a start strobe the block captures all records and the board parity. It then plays out a 32-clock frame: first one K-character header word, then the records packed end to end into 16-bit words with no gaps, then zero words until the window closes.

The header code tells the receiver whether any cell fired and whether the board number is odd or even. The receiver rebuilds the 20-bit records from the 16-bit stream. No calibration or timing conversion is done here, and the record fields pass through bit for bit.

Top module: `tc_frame_serializer`

## Requirements
- R1: Record c sits at `recordsIn[c*20 +: 20]`. Inside a record, bit 19 is the fire flag, bits 18:12 are the timing and bits 11:0 are the energy. The payload stream is record 0 first, each record most significant bit first, with no gaps between records.
- R2: The header word is 0x00FB with `kFlag` high when at least one captured fire flag is set and `boardOdd` is 1.
- R3: The header word is 0x00FD with `kFlag` high when at least one captured fire flag is set and `boardOdd` is 0.
- R4: The header word is 0x00F7 with `kFlag` high when no captured fire flag is set. This holds whatever the timing bits, energy bits and board parity are.
- R5: Frame slots 1 to 15 carry the payload. Slot k carries stream bits 16*(k-1) to 16*(k-1)+15 counted from the stream start, with the earliest bit in bit 15. `kFlag` is low in these slots.
- R6: Frame slots 16 to 31 carry the word 0x0000 with `kFlag` low and `wordValid` high.
- R7: A start that is accepted at a clock edge makes `busy` and `wordValid` high for exactly the next 32 cycles. Slot 0, the header, comes in the first of those cycles.
- R8: A start strobe that arrives while `busy` is high is ignored. Changes on `recordsIn` or `boardOdd` during a frame do not alter the words being sent, because the inputs are captured when the start is accepted.
- R9: After reset, and in every cycle where `wordValid` is low, `busy`, `wordValid` and `kFlag` are 0 and `wordOut` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe; captures inputs and begins a frame when idle |
| boardOdd | input | 1 | Least significant bit of the board number |
| recordsIn | input | 240 | Twelve 20-bit cell records, record 0 in the low bits |
| wordOut | output | 16 | Link word for the current frame slot |
| kFlag | output | 1 | High when wordOut is a K-character header |
| wordValid | output | 1 | High in each of the 32 frame slots |
| busy | output | 1 | High while a frame is being sent |

## Verification
The hardest case to reach is a second start strobe, together with new record contents, landing inside a running frame. That includes the last busy slot, where a one-cycle slip in the capture logic would either start a spurious frame or corrupt the payload. The bench pulses start again in the middle of a frame and again in slot 31, each time with different records and parity. The scoreboard then shows that no word arrives without an expected item, and that the payload still matches the first capture. Sparse walking patterns in the first and last record check that each record field lands on the right bit across the 16-bit word seams.

// File: rtl/tcfs_pkg.sv
package tcfs_pkg;

  localparam logic [7:0] K_HIT_ODD  = 8'hFB;
  localparam logic [7:0] K_HIT_EVEN = 8'hFD;
  localparam logic [7:0] K_NO_HIT   = 8'hF7;

  typedef struct packed {
    logic load;
    logic hdrSel;
    logic paySel;
  } ctrlStrobes_t;

endpackage

// File: rtl/tcfs_ctrl.sv
module tcfs_ctrl
  import tcfs_pkg::*;
#(
  parameter int unsigned FRAME_CLKS = 32,
  parameter int unsigned PAY_WORDS  = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startIn,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  localparam int unsigned SLOT_W = $clog2(FRAME_CLKS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_CLKS - 1);
  localparam logic [SLOT_W-1:0] LAST_PAY  = SLOT_W'(PAY_WORDS);

  logic              active;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (!active) begin
      if (startIn) begin
        active <= 1'b1;
        slot   <= '0;
      end
    end else if (slot == LAST_SLOT) begin
      active <= 1'b0;
      slot   <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    strobes.load   = startIn && !active;
    strobes.hdrSel = active && (slot == '0);
    strobes.paySel = active && (slot != '0) && (slot <= LAST_PAY);
  end

  assign busy = active;

endmodule

// File: rtl/tcfs_datapath.sv
module tcfs_datapath
  import tcfs_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 12,
  parameter int unsigned REC_W     = 20,
  parameter int unsigned WORD_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobes_t               strobes,
  input  logic                       boardOdd,
  input  logic [NUM_CELLS*REC_W-1:0] recordsIn,
  output logic [WORD_W-1:0]          wordOut,
  output logic                       kFlag
);

  localparam int unsigned PAY_BITS  = NUM_CELLS * REC_W;
  localparam int unsigned PAY_WORDS = (PAY_BITS + WORD_W - 1) / WORD_W;
  localparam int unsigned PAY_PAD   = PAY_WORDS * WORD_W;
  localparam int unsigned IDX_W     = $clog2(PAY_WORDS) + 1;

  logic [PAY_PAD-1:0]   packedNext;
  logic [PAY_PAD-1:0]   payReg;
  logic [7:0]           hdrNext;
  logic [7:0]           hdrReg;
  logic                 anyFire;
  logic [IDX_W-1:0]     wordIdx;
  logic [WORD_W-1:0]    wordArr [PAY_WORDS];

  // Concatenate records, record 0 at the stream head, zero padding at the tail.
  always_comb begin
    packedNext = '0;
    anyFire    = 1'b0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      packedNext[PAY_PAD-1-c*REC_W -: REC_W] = recordsIn[c*REC_W +: REC_W];
      anyFire = anyFire | recordsIn[c*REC_W + REC_W - 1];
    end
  end

  always_comb begin
    if (!anyFire)      hdrNext = K_NO_HIT;
    else if (boardOdd) hdrNext = K_HIT_ODD;
    else               hdrNext = K_HIT_EVEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      payReg  <= '0;
      hdrReg  <= K_NO_HIT;
      wordIdx <= '0;
    end else if (strobes.load) begin
      payReg  <= packedNext;
      hdrReg  <= hdrNext;
      wordIdx <= '0;
    end else if (strobes.paySel) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  for (genvar w = 0; w < PAY_WORDS; w++) begin : g_slice
    assign wordArr[w] = payReg[PAY_PAD-1-w*WORD_W -: WORD_W];
  end

  always_comb begin
    wordOut = '0;
    if (strobes.hdrSel)
      wordOut = {{(WORD_W-8){1'b0}}, hdrReg};
    else if (strobes.paySel && (wordIdx < IDX_W'(PAY_WORDS)))
      wordOut = wordArr[wordIdx];
  end

  assign kFlag = strobes.hdrSel;

endmodule

// File: rtl/tc_frame_serializer.sv
module tc_frame_serializer
  import tcfs_pkg::*;
#(
  parameter int unsigned NUM_CELLS  = 12,
  parameter int unsigned TIME_W     = 7,
  parameter int unsigned ENERGY_W   = 12,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FRAME_CLKS = 32,
  localparam int unsigned REC_W     = 1 + TIME_W + ENERGY_W,
  localparam int unsigned PAY_WORDS = (NUM_CELLS * REC_W + WORD_W - 1) / WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       startIn,
  input  logic                       boardOdd,
  input  logic [NUM_CELLS*REC_W-1:0] recordsIn,
  output logic [WORD_W-1:0]          wordOut,
  output logic                       kFlag,
  output logic                       wordValid,
  output logic                       busy
);

  ctrlStrobes_t strobes;
  logic         frameActive;

  tcfs_ctrl #(
    .FRAME_CLKS(FRAME_CLKS),
    .PAY_WORDS (PAY_WORDS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .startIn(startIn),
    .strobes(strobes),
    .busy   (frameActive)
  );

  tcfs_datapath #(
    .NUM_CELLS(NUM_CELLS),
    .REC_W    (REC_W),
    .WORD_W   (WORD_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .boardOdd (boardOdd),
    .recordsIn(recordsIn),
    .wordOut  (wordOut),
    .kFlag    (kFlag)
  );

  assign busy      = frameActive;
  assign wordValid = frameActive;

endmodule

// File: rtl/tcfs_checker.sv
module tcfs_checker #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FRAME_CLKS = 32,
  parameter int unsigned PAY_WORDS  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startIn,
  input logic [WORD_W-1:0] wordOut,
  input logic              kFlag,
  input logic              wordValid,
  input logic              busy
);

  localparam int unsigned CNT_W = $clog2(FRAME_CLKS) + 1;

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  // R2 R3 R4: header words carry one of three codes with a zero upper byte
  p_hdr_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kFlag |-> (wordOut == 16'h00FB || wordOut == 16'h00FD || wordOut == 16'h00F7));

  // R7: the first busy slot is the header
  p_hdr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt == '0) |-> kFlag);

  // R5: only one header per frame
  p_single_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt != '0) |-> !kFlag);

  // R6: padding slots are zero
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt > CNT_W'(PAY_WORDS)) |-> (wordOut == '0 && wordValid));

  // R7: a frame lasts exactly FRAME_CLKS cycles
  p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt == CNT_W'(FRAME_CLKS - 1)) |=> !busy);

  p_no_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runCnt < CNT_W'(FRAME_CLKS - 1)) |=> busy);

  // R8: start during a frame never restarts the header
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startIn && runCnt < CNT_W'(FRAME_CLKS - 1)) |=> !kFlag);

  // R9: idle outputs are quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wordValid |-> (!kFlag && wordOut == '0 && !busy));

endmodule

bind tc_frame_serializer tcfs_checker #(
  .WORD_W    (WORD_W),
  .FRAME_CLKS(FRAME_CLKS),
  .PAY_WORDS (PAY_WORDS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .startIn  (startIn),
  .wordOut  (wordOut),
  .kFlag    (kFlag),
  .wordValid(wordValid),
  .busy     (busy)
);

// File: tb/tc_frame_serializer_tb.sv
module tc_frame_serializer_tb;

  localparam int CELLS  = 12;
  localparam int RW     = 20;
  localparam int NBITS  = CELLS * RW;
  localparam int FRAME  = 32;
  localparam int PWORDS = 15;

  typedef struct {
    logic [15:0] word;
    logic        k;
    int          slot;
    int          req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startIn = 1'b0;
  logic             boardOdd = 1'b0;
  logic [NBITS-1:0] recordsIn = '0;
  logic [15:0]      wordOut;
  logic             kFlag;
  logic             wordValid;
  logic             busy;

  int total = 0;
  int bad   = 0;
  int busyRun = 0;
  bit finished = 0;
  item_t expQ[$];

  always #10 clk = ~clk;

  tc_frame_serializer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .startIn  (startIn),
    .boardOdd (boardOdd),
    .recordsIn(recordsIn),
    .wordOut  (wordOut),
    .kFlag    (kFlag),
    .wordValid(wordValid),
    .busy     (busy)
  );

  function automatic string reqName(int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, int r, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", reqName(r), what, act, exp);
    end
  endtask

  // Driver: build the expected frame from the requirements, then strobe start.
  task automatic sendFrame(input logic [NBITS-1:0] recs, input logic odd, input int payReq);
    logic [NBITS-1:0] stream;
    bit fired;
    item_t it;
    fired = 0;
    for (int c = 0; c < CELLS; c++) begin
      if (recs[c*RW + 19]) fired = 1;
      for (int b = 0; b < RW; b++)
        stream[NBITS-1 - c*RW - b] = recs[c*RW + 19 - b];
    end
    it.slot = 0;
    it.k = 1'b1;
    if (!fired)   begin it.word = 16'h00F7; it.req = 4; end
    else if (odd) begin it.word = 16'h00FB; it.req = 2; end
    else          begin it.word = 16'h00FD; it.req = 3; end
    expQ.push_back(it);
    for (int s = 1; s < FRAME; s++) begin
      it.slot = s;
      it.k = 1'b0;
      if (s <= PWORDS) begin
        it.word = stream[NBITS-1-(s-1)*16 -: 16];
        it.req = payReq;
      end else begin
        it.word = 16'h0000;
        it.req = 6;
      end
      expQ.push_back(it);
    end
    @(negedge clk);
    recordsIn = recs;
    boardOdd  = odd;
    startIn   = 1'b1;
    @(negedge clk);
    startIn   = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < FRAME + 4; i++) @(negedge clk);
  endtask

  // Monitor: compare every valid word against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == wordValid, 7, "busy vs valid", {31'b0, busy}, {31'b0, wordValid});
      if (wordValid) begin
        busyRun++;
        if (expQ.size() == 0) begin
          check(0, 8, "unexpected word", {15'b0, kFlag, wordOut}, 32'h0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check({kFlag, wordOut} == {e.k, e.word}, e.req,
                $sformatf("slot %0d", e.slot), {15'b0, kFlag, wordOut}, {15'b0, e.k, e.word});
        end
      end else begin
        if (busyRun != 0)
          check(busyRun == FRAME, 7, "frame length", busyRun, FRAME);
        busyRun = 0;
        if (kFlag || wordOut != 16'h0)
          check(0, 9, "idle quiet", {15'b0, kFlag, wordOut}, 32'h0);
      end
    end
  end

  function automatic logic [NBITS-1:0] mkRec(int c, logic f, logic [6:0] t, logic [11:0] e);
    logic [NBITS-1:0] v;
    v = '0;
    v[c*RW +: RW] = {f, t, e};
    return v;
  endfunction

  initial begin
    logic [NBITS-1:0] r;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !wordValid && !kFlag && wordOut == 16'h0, 9, "reset outputs",
          {14'b0, busy, wordValid, wordOut}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wordValid, 9, "idle after reset", {30'b0, busy, wordValid}, 32'h0);

    // R1 R5: only cell 0 fire bit, odd board (R2)
    sendFrame(mkRec(0, 1'b1, 7'h00, 12'h000), 1'b1, 1);
    waitIdle();
    // R1: last cell energy LSB only, no fire (R4)
    sendFrame(mkRec(11, 1'b0, 7'h00, 12'h001), 1'b1, 1);
    waitIdle();
    // R1: timing field walking pattern in cell 5, even board (R3)
    sendFrame(mkRec(5, 1'b1, 7'h55, 12'hA5C) | mkRec(6, 1'b0, 7'h7F, 12'h000), 1'b0, 5);
    waitIdle();
    // R4: busy timing/energy bits, no fire, even board
    r = '0;
    for (int c = 0; c < CELLS; c++) r |= mkRec(c, 1'b0, 7'(c * 9 + 3), 12'(c * 301 + 17));
    sendFrame(r, 1'b0, 5);
    waitIdle();
    // R3: all ones, board even
    sendFrame({NBITS{1'b1}}, 1'b0, 5);
    waitIdle();
    // R2: mixed pattern, several fired, odd board
    r = '0;
    for (int c = 0; c < CELLS; c++) r |= mkRec(c, c[0], 7'(c * 11), 12'(12'hF00 ^ (c * 257)));
    sendFrame(r, 1'b1, 5);
    // R8: mid-frame start with new inputs must be ignored
    repeat (10) @(negedge clk);
    recordsIn = {NBITS{1'b1}};
    boardOdd  = 1'b0;
    startIn   = 1'b1;
    @(negedge clk);
    startIn   = 1'b0;
    // R8: start in last busy slot (slot 31) is also ignored
    while (!(busy && expQ.size() == 1)) @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy && expQ.size() == 0, 8, "no restart after ignored start",
          {31'b0, busy}, 32'h0);
    // R7: back-to-back accepted frames
    sendFrame(mkRec(3, 1'b1, 7'h12, 12'h345), 1'b0, 5);
    while (busy) @(negedge clk);
    sendFrame(mkRec(9, 1'b1, 7'h6A, 12'hBCD), 1'b1, 5);
    waitIdle();
    check(expQ.size() == 0, 7, "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule